// File: doc/BRIEF.md
# Periodic Interrupt Timer with Vectoring

This block is a free-running down-counter that raises a periodic interrupt request. Software-style write strobes load a period, a 3-bit request level and an 8-bit vector number. Each time the count expires, a sticky pending flag is set, as long as the level is nonzero. The flag stays set until the processor acknowledges the timer's request. On that acknowledge the programmed vector is presented for one cycle.

The timer request is arbitrated against one external request. When both have the same level, the timer wins. The winning level is then compared with the processor's priority mask. The counter keeps running while the level is zero. Loading a period of zero is the only way to stop it. The request outputs are registered, so they reflect the state one clock earlier.

Top module: `pit_vec_top`

## Requirements
- R1: After synchronous reset, the block is in this state:
  - the period is zero (stopped) and the level is zero;
  - the vector register holds 0x0F;
  - `pend_o`, `irq_o` and `vec_valid_o` are 0, and `vec_o` reads 0x0F.
  
  An acknowledge before any vector write returns 0x0F.
- R2: With a nonzero period P loaded at clock edge k and a nonzero level, `pend_o` rises after edge k+P. It is then set again every P edges.
- R3: While the level is 0 the counter keeps counting, but no pending flag is set. When a nonzero level is written later, the next pending flag follows the original count phase.
- R4: While the period register holds zero, the counter is frozen and `pend_o` never rises.
- R5: Writing a new nonzero period restarts the count from that value on the same edge. The next pending flag comes P edges later, whatever the old count was.
- R6: A winning level L is recognised (`irq_o`=1) when L is nonzero and either L is 7 or L is strictly greater than `cpu_mask_i`.
- R7: The timer takes part in arbitration when it is pending with a nonzero level. The external request takes part when `ext_req_i` is 1 with a nonzero level.
  - The timer wins when its level is greater than or equal to the external level.
  - `irq_src_o` is 1 for the timer and 0 for the external request.
  - `irq_level_o` carries the winning level, or 0 when neither side takes part.
- R8: An `iack_i` that meets a recognised timer win does three things on that edge:
  - clears the pending flag;
  - drives `vec_o` with the vector register;
  - sets `vec_valid_o` for one cycle.
  
  An acknowledge taken while the external request wins leaves the pending flag set and `vec_valid_o` at 0.
- R9: The pending flag stays set until it is cleared as in R8. If an acknowledge falls on the same edge as a terminal count, the flag stays set.
- R10: `irq_o`, `irq_level_o` and `irq_src_o` are registered. They reflect the pending state and inputs of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_we_i | input | 1 | Load strobe for the period register |
| period_i | input | CNT_W | New period value (0 stops the timer) |
| level_we_i | input | 1 | Load strobe for the request level |
| level_i | input | 3 | New request level (0 disables the request) |
| vector_we_i | input | 1 | Load strobe for the vector register |
| vector_i | input | VEC_W | New vector number |
| ext_req_i | input | 1 | External interrupt request |
| ext_level_i | input | 3 | Level of the external request |
| cpu_mask_i | input | 3 | Processor interrupt priority mask |
| iack_i | input | 1 | Interrupt acknowledge |
| pend_o | output | 1 | Timer pending flag |
| irq_o | output | 1 | Recognised interrupt request |
| irq_level_o | output | 3 | Level of the arbitration winner |
| irq_src_o | output | 1 | 1 when the timer is the winner |
| vec_valid_o | output | 1 | Vector presented this cycle |
| vec_o | output | VEC_W | Presented vector number |

## Verification
An acknowledge and a terminal count can land on the same clock edge. One would clear the pending flag and the other would set it. The bench sets a period of 4 and counts edges from the period write. It then holds `iack_i` across exactly the edge of the second expiry. The pass condition is that `pend_o` stays 1 while `vec_valid_o` pulses with the programmed vector. A same-level tie between the timer and the external request is also provoked directly. The expected winner comes from a bench function that applies the arbitration and mask rules.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int LVL_W   = 3;
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  typedef logic [LVL_W-1:0] lvl_t;

  // a level passes the mask when above it; the top level always passes
  function automatic logic lvl_passes(input lvl_t lvl, input lvl_t mask);
    return (lvl != '0) && ((lvl == lvl_t'(LVL_MAX)) || (lvl > mask));
  endfunction
endpackage

// File: rtl/pit_cfg_regs.sv
module pit_cfg_regs
  import pit_pkg::*;
#(
  parameter int              CNT_W   = 16,
  parameter int              VEC_W   = 8,
  parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             period_we_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             level_we_i,
  input  lvl_t             level_i,
  input  logic             vector_we_i,
  input  logic [VEC_W-1:0] vector_i,
  output logic [CNT_W-1:0] period_q,
  output lvl_t             level_q,
  output logic [VEC_W-1:0] vector_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      level_q  <= '0;
      vector_q <= VEC_RST;
    end else begin
      if (period_we_i) period_q <= period_i;
      if (level_we_i)  level_q  <= level_i;
      if (vector_we_i) vector_q <= vector_i;
    end
  end
endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic running;
  assign running = (period_i != '0);
  assign tick_o  = !load_i && running && (cnt_o == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (load_i) begin
      cnt_o <= load_val_i;
    end else if (running) begin
      if (cnt_o <= ONE) cnt_o <= period_i;
      else              cnt_o <= cnt_o - ONE;
    end
  end
endmodule

// File: rtl/pit_arbiter.sv
module pit_arbiter
  import pit_pkg::*;
#(
  parameter int               VEC_W   = 8,
  parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pend_i,
  input  lvl_t             tim_level_i,
  input  logic [VEC_W-1:0] vector_i,
  input  logic             ext_req_i,
  input  lvl_t             ext_level_i,
  input  lvl_t             cpu_mask_i,
  input  logic             iack_i,
  output logic             timer_ack_o,
  output logic             irq_o,
  output lvl_t             irq_level_o,
  output logic             irq_src_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o
);
  logic t_req, e_req, t_win, rec;
  lvl_t win_lvl;

  always_comb begin
    t_req   = pend_i && (tim_level_i != '0);
    e_req   = ext_req_i && (ext_level_i != '0);
    t_win   = t_req && (!e_req || (tim_level_i >= ext_level_i));
    if (t_win)      win_lvl = tim_level_i;
    else if (e_req) win_lvl = ext_level_i;
    else            win_lvl = '0;
    rec = lvl_passes(win_lvl, cpu_mask_i);
  end

  assign timer_ack_o = iack_i && rec && t_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o       <= 1'b0;
      irq_level_o <= '0;
      irq_src_o   <= 1'b0;
      vec_valid_o <= 1'b0;
      vec_o       <= VEC_RST;
    end else begin
      irq_o       <= rec;
      irq_level_o <= win_lvl;
      irq_src_o   <= t_win;
      vec_valid_o <= timer_ack_o;
      if (timer_ack_o) vec_o <= vector_i;
    end
  end
endmodule

// File: rtl/pit_vec_top.sv
module pit_vec_top
  import pit_pkg::*;
#(
  parameter int               CNT_W   = 16,
  parameter int               VEC_W   = 8,
  parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             period_we_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             level_we_i,
  input  logic [2:0]       level_i,
  input  logic             vector_we_i,
  input  logic [VEC_W-1:0] vector_i,
  input  logic             ext_req_i,
  input  logic [2:0]       ext_level_i,
  input  logic [2:0]       cpu_mask_i,
  input  logic             iack_i,
  output logic             pend_o,
  output logic             irq_o,
  output logic [2:0]       irq_level_o,
  output logic             irq_src_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [CNT_W-1:0] period_q;
  lvl_t             level_q;
  logic [VEC_W-1:0] vector_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;
  logic             timer_ack;
  logic             pend_q;

  pit_cfg_regs #(.CNT_W(CNT_W), .VEC_W(VEC_W), .VEC_RST(VEC_RST)) u_regs (
    .clk(clk), .rst(rst),
    .period_we_i(period_we_i), .period_i(period_i),
    .level_we_i(level_we_i),   .level_i(level_i),
    .vector_we_i(vector_we_i), .vector_i(vector_i),
    .period_q(period_q), .level_q(level_q), .vector_q(vector_q)
  );

  pit_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .load_i(period_we_i), .load_val_i(period_i),
    .period_i(period_q),
    .cnt_o(cnt_q), .tick_o(tick)
  );

  pit_arbiter #(.VEC_W(VEC_W), .VEC_RST(VEC_RST)) u_arb (
    .clk(clk), .rst(rst),
    .pend_i(pend_q), .tim_level_i(level_q), .vector_i(vector_q),
    .ext_req_i(ext_req_i), .ext_level_i(ext_level_i),
    .cpu_mask_i(cpu_mask_i), .iack_i(iack_i),
    .timer_ack_o(timer_ack),
    .irq_o(irq_o), .irq_level_o(irq_level_o), .irq_src_o(irq_src_o),
    .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  // sticky pending flag: a new expiry beats a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (pend_q && !timer_ack) || (tick && (level_q != '0));
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pit_vec_chk.sv
module pit_vec_chk #(
  parameter int               CNT_W   = 16,
  parameter int               VEC_W   = 8,
  parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
  input logic             clk,
  input logic             rst,
  input logic             period_we_i,
  input logic [CNT_W-1:0] period_q,
  input logic [2:0]       level_q,
  input logic [VEC_W-1:0] vector_q,
  input logic             tick,
  input logic             timer_ack,
  input logic             pend_q,
  input logic             iack_i,
  input logic [2:0]       cpu_mask_i,
  input logic             irq_o,
  input logic [2:0]       irq_level_o,
  input logic             irq_src_o,
  input logic             vec_valid_o,
  input logic [VEC_W-1:0] vec_o
);
  assert_reset_vec_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vec_o == VEC_RST) && !irq_o && !vec_valid_o);

  assert_stopped_R4: assert property (@(posedge clk) disable iff (rst)
    (period_q == '0 && !period_we_i && !pend_q) |=> !pend_q);

  assert_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && level_q == 3'd0 && !pend_q) |=> !pend_q);

  assert_recognised_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (irq_level_o != 3'd0) &&
              ((irq_level_o == 3'd7) || (irq_level_o > $past(cpu_mask_i))));

  assert_tie_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_src_o) |->
      !($past(pend_q) && $past(level_q) != 3'd0 && $past(level_q) >= irq_level_o));

  assert_vector_R8: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> (vec_o == $past(vector_q)) && $past(iack_i));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (timer_ack && !tick) |=> !pend_q);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !iack_i) |=> pend_q);
endmodule

bind pit_vec_top pit_vec_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W), .VEC_RST(VEC_RST)) chk_i (
  .clk(clk), .rst(rst), .period_we_i(period_we_i),
  .period_q(period_q), .level_q(level_q), .vector_q(vector_q),
  .tick(tick), .timer_ack(timer_ack), .pend_q(pend_q),
  .iack_i(iack_i), .cpu_mask_i(cpu_mask_i),
  .irq_o(irq_o), .irq_level_o(irq_level_o), .irq_src_o(irq_src_o),
  .vec_valid_o(vec_valid_o), .vec_o(vec_o)
);

// File: tb/pit_vec_top_tb_top.sv
`timescale 1ns/1ps
module pit_vec_top_tb_top;
  localparam int CNT_W = 16;
  localparam int VEC_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic period_we_i = 0, level_we_i = 0, vector_we_i = 0;
  logic [CNT_W-1:0] period_i = '0;
  logic [2:0] level_i = '0, ext_level_i = '0, cpu_mask_i = '0;
  logic [VEC_W-1:0] vector_i = '0;
  logic ext_req_i = 0, iack_i = 0;
  logic pend_o, irq_o, irq_src_o, vec_valid_o;
  logic [2:0] irq_level_o;
  logic [VEC_W-1:0] vec_o;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  pit_vec_top #(.CNT_W(CNT_W), .VEC_W(VEC_W)) dut_i (
    .clk(clk), .rst(rst),
    .period_we_i(period_we_i), .period_i(period_i),
    .level_we_i(level_we_i), .level_i(level_i),
    .vector_we_i(vector_we_i), .vector_i(vector_i),
    .ext_req_i(ext_req_i), .ext_level_i(ext_level_i),
    .cpu_mask_i(cpu_mask_i), .iack_i(iack_i),
    .pend_o(pend_o), .irq_o(irq_o), .irq_level_o(irq_level_o),
    .irq_src_o(irq_src_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_period(input int p);
    period_i = CNT_W'(p); period_we_i = 1; step(1); period_we_i = 0;
  endtask

  task automatic wr_level(input int l);
    level_i = 3'(l); level_we_i = 1; step(1); level_we_i = 0;
  endtask

  task automatic wr_both(input int p, input int l);
    period_i = CNT_W'(p); level_i = 3'(l);
    period_we_i = 1; level_we_i = 1; step(1);
    period_we_i = 0; level_we_i = 0;
  endtask

  task automatic ack1();
    iack_i = 1; step(1); iack_i = 0;
  endtask

  // stop the timer and drop any pending flag
  task automatic quiesce();
    ext_req_i = 0; cpu_mask_i = 0;
    wr_both(0, 1);
    ack1();
  endtask

  function automatic void exp_arb(input int tl, input int er, input int el, input int m,
                                  output int rec, output int lvl, output int src);
    bit t, e;
    t   = (tl != 0);
    e   = (er != 0) && (el != 0);
    src = (t && (!e || tl >= el)) ? 1 : 0;
    lvl = (src != 0) ? tl : (e ? el : 0);
    rec = (lvl != 0 && (lvl == 7 || lvl > m)) ? 1 : 0;
  endfunction

  // timer pending must already be set; level write then one registered cycle
  task automatic arb_case(input int tl, input int er, input int el, input int m);
    int rec, lvl, src;
    wr_level(tl);
    ext_req_i = er[0]; ext_level_i = 3'(el); cpu_mask_i = 3'(m);
    step(1);
    exp_arb(tl, er, el, m, rec, lvl, src);
    chk("R6 irq_o", {31'd0, irq_o}, 32'(rec));
    chk("R7 irq_level_o", {29'd0, irq_level_o}, 32'(lvl));
    chk("R7 irq_src_o", {31'd0, irq_src_o}, 32'(src));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    step(3);
    rst = 0;
    step(1);
    // R1 reset state
    chk("R1 pend", {31'd0, pend_o}, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 vec_valid", {31'd0, vec_valid_o}, 0);
    chk("R1 vec_o", {24'd0, vec_o}, 32'h0F);
    step(20);
    chk("R1 stopped after reset", {31'd0, pend_o}, 0);

    // R2 period 5 level 3, R10 registered request
    wr_both(5, 3);
    step(4); chk("R2 not yet", {31'd0, pend_o}, 0);
    step(1); chk("R2 pend at P", {31'd0, pend_o}, 1);
    chk("R10 irq lags", {31'd0, irq_o}, 0);
    step(1);
    chk("R10 irq", {31'd0, irq_o}, 1);
    chk("R10 level", {29'd0, irq_level_o}, 3);
    chk("R10 src", {31'd0, irq_src_o}, 1);
    step(10); chk("R9 sticky", {31'd0, pend_o}, 1);
    ack1();
    chk("R8 cleared", {31'd0, pend_o}, 0);
    chk("R8 vec_valid", {31'd0, vec_valid_o}, 1);
    chk("R1 reset vector", {24'd0, vec_o}, 32'h0F);
    step(1); chk("R8 one cycle", {31'd0, vec_valid_o}, 0);
    wr_period(0);
    step(30); chk("R4 zero period", {31'd0, pend_o}, 0);

    // R9 ack on the expiry edge
    vector_i = 8'hA5; vector_we_i = 1; step(1); vector_we_i = 0;
    wr_period(4);
    step(4); chk("R2 period 4", {31'd0, pend_o}, 1);
    step(3);
    ack1();
    chk("R9 same-edge set wins", {31'd0, pend_o}, 1);
    chk("R8 vec_valid", {31'd0, vec_valid_o}, 1);
    chk("R8 vector", {24'd0, vec_o}, 32'hA5);
    quiesce();
    chk("R8 clear", {31'd0, pend_o}, 0);

    // R3 counter runs while disabled
    wr_both(6, 0);
    step(6); chk("R3 no pend at level 0", {31'd0, pend_o}, 0);
    wr_level(3);
    step(4); chk("R3 before phase", {31'd0, pend_o}, 0);
    step(1); chk("R3 phase kept", {31'd0, pend_o}, 1);
    quiesce();

    // R5 restart on new period
    wr_both(10, 2);
    step(2);
    wr_period(4);
    step(3); chk("R5 before", {31'd0, pend_o}, 0);
    step(1); chk("R5 restarted", {31'd0, pend_o}, 1);
    quiesce();

    // R4 stop mid-count
    wr_both(8, 2);
    step(3);
    wr_period(0);
    step(20); chk("R4 stopped mid-count", {31'd0, pend_o}, 0);

    // R8 ack while external wins leaves pend
    wr_both(1, 2);
    step(1);
    wr_period(0);
    chk("R2 period 1", {31'd0, pend_o}, 1);
    ext_req_i = 1; ext_level_i = 5; cpu_mask_i = 0;
    step(1);
    ack1();
    chk("R8 ext ack keeps pend", {31'd0, pend_o}, 1);
    chk("R8 no vector", {31'd0, vec_valid_o}, 0);

    // R6/R7 directed corners
    arb_case(4, 1, 4, 0);
    arb_case(4, 1, 5, 0);
    arb_case(6, 0, 0, 7);
    arb_case(7, 0, 0, 7);
    arb_case(3, 0, 0, 3);
    arb_case(0, 1, 2, 1);
    arb_case(0, 0, 0, 0);
    // R6/R7 random
    for (int i = 0; i < 150; i++) begin
      arb_case(int'($urandom_range(0, 7)), int'($urandom_range(0, 1)),
               int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
    end
    chk("R9 still pending", {31'd0, pend_o}, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule